// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block is the master end of a multi-slot time-division-multiplexed audio serial link. An integer divider turns the system clock into a one-cycle bit-clock enable. On each bit period the block drives a frame-sync level and one data bit, walking through a frame made of a programmable number of equal-width slots. Sample words arrive on a valid/ready stream and are placed into the slots that a per-slot enable mask selects. Slots whose enable bit is clear carry zeros.

Settings are captured from the configuration inputs only while the block is disabled. These settings are: divider, slot width, data width, total slots, frame-sync width and polarity, one-bit data delay, bit order and skip mode. Raising the enable starts a new frame at slot 0. In skip mode the stream feeds only enabled slots. Otherwise every slot takes one word and words that fall on disabled slots are dropped. If an enabled slot starts with no word available, it is sent as zeros and an underrun pulse is raised.

Top module: `tdm_tx`

## Requirements
- R1: `bclk_en_o` is a one-cycle pulse repeating every max(`cfg_div_i`, 8) clock cycles while enabled; divider settings below 8 behave as 8.
- R2: The frame has N slots, where N is the larger of min(`cfg_total_slots_i`, MAX_SLOTS) and (highest set mask bit index + 1); with an empty mask the second term is 1. The frame length is slot width × N bit periods, and the first bit period after enable is frame position 0.
- R3: `ws_o` is at the active level for the first W bit periods of each frame and at the inactive level for the rest. W is `cfg_fs_width_i`, or half the frame length (rounded down) when that input is 0. The active level is 1 when `cfg_fs_pol_i`=1 and 0 otherwise.
- R4: The sample occupies the low D bits of `s_data_i`, where D is the effective data width. D is `cfg_data_bits_i` clamped to the range 1..slot width; the slot width is clamped to 1..MAX_BITS. The sample fills the first D bit periods of its slot, sample bit D-1 first (`cfg_lsb_first_i`=0) or sample bit 0 first (=1). The remaining bit periods of the slot carry 0, and `s_data_i` bits at D and above are ignored.
- R5: With `cfg_bit_shift_i`=1 the data line lags the R4 bit stream by exactly one bit period, and the first bit after enable is 0. With it at 0, the first sample bit of slot 0 coincides with the frame-sync start.
- R6: A slot whose bit in `cfg_slot_mask_i` is 0 (bit i for slot i) carries only zeros.
- R7: A stream word is taken at the first bit period of a slot. With `cfg_skip_mask_i`=1 this happens only for enabled slots. With it at 0 it happens for every slot, and words taken for disabled slots are discarded.
- R8: When an enabled slot starts and `s_valid_i` is 0, the slot carries zeros and `underrun_o` is high for one cycle.
- R9: While `en_i`=0: `bclk_en_o`, `s_ready_o`, `sd_o` and `underrun_o` are 0, and `ws_o` is at the inactive level.
- R10: Changes to any configuration input while `en_i`=1 have no effect on the output until the next disabled period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low captures configuration |
| cfg_div_i | input | DIV_W | Clocks per bit period (min 8) |
| cfg_slot_bits_i | input | $clog2(MAX_BITS+1) | Bits per slot |
| cfg_data_bits_i | input | $clog2(MAX_BITS+1) | Valid sample bits per slot |
| cfg_total_slots_i | input | $clog2(MAX_SLOTS+1) | Requested slots per frame |
| cfg_slot_mask_i | input | MAX_SLOTS | Per-slot enable |
| cfg_fs_width_i | input | $clog2(MAX_SLOTS*MAX_BITS+1) | Frame-sync width in bit periods, 0 = half frame |
| cfg_fs_pol_i | input | 1 | Frame-sync active level |
| cfg_bit_shift_i | input | 1 | One-bit data delay |
| cfg_lsb_first_i | input | 1 | Send sample LSB first |
| cfg_skip_mask_i | input | 1 | Stream feeds enabled slots only |
| s_valid_i | input | 1 | Sample word valid |
| s_data_i | input | MAX_BITS | Sample word, right-justified |
| s_ready_o | output | 1 | Sample word taken this cycle |
| bclk_en_o | output | 1 | Bit-clock enable pulse |
| ws_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Enabled slot started without a word |

## Verification
The bench targets these corner cases:
- Divider values under 8. A missing clamp shortens the bit period.
- A total slot count below the highest enabled slot. A wrong frame-length rule moves the frame sync and misplaces every later slot.
- A frame-sync width of 0. Getting it wrong breaks the half-frame duty.
- Data narrower than the slot, with bit order reversed. The padding zeros and the bit selection expose a wrong index or stray upper bits.
- Both skip modes over a sparse mask, compared by word count and slot contents. A design that consumes for the wrong slots shifts the whole stream.
- Configuration that changes mid-frame, with a design that lets it through.
- Stream starvation, against a design that repeats stale data or misses the underrun pulse.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int unsigned TDM_MIN_DIV = 8;

  function automatic logic fs_level(input logic in_sync, input logic pol);
    return in_sync ? pol : ~pol;
  endfunction
endpackage

// File: rtl/tdm_tx_clkdiv.sv
module tdm_tx_clkdiv
  import tdm_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] eff_div, cnt_q;

  assign eff_div = (div_i < DIV_W'(TDM_MIN_DIV)) ? DIV_W'(TDM_MIN_DIV) : div_i;
  assign tick_o  = run_i && (cnt_q == eff_div - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end

  // period checker
  logic [DIV_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!run_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + DIV_W'(1);
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1
  AST_TICK_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && seen_q) |-> (gap_q == eff_div - DIV_W'(1))); // R1
endmodule

// File: rtl/tdm_tx_cfg.sv
module tdm_tx_cfg #(
  parameter int unsigned MAX_SLOTS = 8,
  parameter int unsigned MAX_BITS  = 32,
  parameter int unsigned DIV_W     = 8,
  localparam int unsigned BITS_W   = $clog2(MAX_BITS + 1),
  localparam int unsigned CNT_W    = $clog2(MAX_SLOTS + 1),
  localparam int unsigned FB_W     = $clog2(MAX_SLOTS * MAX_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic [BITS_W-1:0]    slot_bits_i,
  input  logic [BITS_W-1:0]    data_bits_i,
  input  logic [CNT_W-1:0]     total_slots_i,
  input  logic [MAX_SLOTS-1:0] slot_mask_i,
  input  logic [FB_W-1:0]      fs_width_i,
  input  logic                 fs_pol_i,
  input  logic                 bit_shift_i,
  input  logic                 lsb_first_i,
  input  logic                 skip_mask_i,
  output logic [DIV_W-1:0]     div_o,
  output logic [BITS_W-1:0]    slot_bits_o,
  output logic [BITS_W-1:0]    data_bits_o,
  output logic [CNT_W-1:0]     nslots_o,
  output logic [FB_W-1:0]      frame_bits_o,
  output logic [FB_W-1:0]      fs_width_o,
  output logic                 fs_pol_o,
  output logic                 bit_shift_o,
  output logic                 lsb_first_o,
  output logic                 skip_mask_o,
  output logic [MAX_SLOTS-1:0] slot_mask_o
);
  logic [BITS_W-1:0] sh_slot, sh_data;
  logic [CNT_W-1:0]  sh_total, need, tot;
  logic [FB_W-1:0]   sh_fs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o       <= '0;
      sh_slot     <= '0;
      sh_data     <= '0;
      sh_total    <= '0;
      slot_mask_o <= '0;
      sh_fs       <= '0;
      fs_pol_o    <= 1'b0;
      bit_shift_o <= 1'b0;
      lsb_first_o <= 1'b0;
      skip_mask_o <= 1'b0;
    end else if (!en_i) begin
      div_o       <= div_i;
      sh_slot     <= slot_bits_i;
      sh_data     <= data_bits_i;
      sh_total    <= total_slots_i;
      slot_mask_o <= slot_mask_i;
      sh_fs       <= fs_width_i;
      fs_pol_o    <= fs_pol_i;
      bit_shift_o <= bit_shift_i;
      lsb_first_o <= lsb_first_i;
      skip_mask_o <= skip_mask_i;
    end
  end

  always_comb begin
    need = CNT_W'(1);
    for (int i = 0; i < int'(MAX_SLOTS); i++)
      if (slot_mask_o[i]) need = CNT_W'(i + 1);
  end

  assign tot = (sh_total > CNT_W'(MAX_SLOTS)) ? CNT_W'(MAX_SLOTS) : sh_total;
  assign nslots_o = (tot < need) ? need : tot;

  assign slot_bits_o = (sh_slot == '0) ? BITS_W'(1) :
                       (sh_slot > BITS_W'(MAX_BITS)) ? BITS_W'(MAX_BITS) : sh_slot;
  assign data_bits_o = (sh_data == '0) ? BITS_W'(1) :
                       (sh_data > slot_bits_o) ? slot_bits_o : sh_data;

  assign frame_bits_o = FB_W'(slot_bits_o) * FB_W'(nslots_o);
  assign fs_width_o   = (sh_fs == '0) ? (frame_bits_o >> 1) : sh_fs;
endmodule

// File: rtl/tdm_tx_seq.sv
module tdm_tx_seq
  import tdm_tx_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 8,
  parameter int unsigned MAX_BITS  = 32,
  localparam int unsigned BITS_W   = $clog2(MAX_BITS + 1),
  localparam int unsigned BIT_W    = $clog2(MAX_BITS),
  localparam int unsigned CNT_W    = $clog2(MAX_SLOTS + 1),
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS),
  localparam int unsigned FB_W     = $clog2(MAX_SLOTS * MAX_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [BITS_W-1:0] slot_bits_i,
  input  logic [CNT_W-1:0]  nslots_i,
  input  logic [FB_W-1:0]   frame_bits_i,
  input  logic [FB_W-1:0]   fs_width_i,
  input  logic              fs_pol_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              ws_o
);
  logic [FB_W-1:0] pos_q;
  logic            last_bit, last_slot;

  assign last_bit  = (bit_o == BIT_W'(slot_bits_i - BITS_W'(1)));
  assign last_slot = (slot_o == SLOT_W'(nslots_i - CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      slot_o <= '0;
      bit_o  <= '0;
      ws_o   <= 1'b0;
    end else if (!run_i) begin
      pos_q  <= '0;
      slot_o <= '0;
      bit_o  <= '0;
      ws_o   <= ~fs_pol_i;
    end else if (tick_i) begin
      ws_o  <= fs_level(pos_q < fs_width_i, fs_pol_i);
      pos_q <= (pos_q == frame_bits_i - FB_W'(1)) ? '0 : pos_q + FB_W'(1);
      if (last_bit) begin
        bit_o  <= '0;
        slot_o <= last_slot ? '0 : slot_o + SLOT_W'(1);
      end else begin
        bit_o  <= bit_o + BIT_W'(1);
      end
    end
  end

  AST_WS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$past(tick_i)) |-> $stable(ws_o)); // R3
  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (CNT_W'(slot_o) < nslots_i)); // R2
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 8,
  parameter int unsigned MAX_BITS  = 32,
  parameter int unsigned DIV_W     = 8,
  localparam int unsigned BITS_W   = $clog2(MAX_BITS + 1),
  localparam int unsigned BIT_W    = $clog2(MAX_BITS),
  localparam int unsigned CNT_W    = $clog2(MAX_SLOTS + 1),
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS),
  localparam int unsigned FB_W     = $clog2(MAX_SLOTS * MAX_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [DIV_W-1:0]     cfg_div_i,
  input  logic [BITS_W-1:0]    cfg_slot_bits_i,
  input  logic [BITS_W-1:0]    cfg_data_bits_i,
  input  logic [CNT_W-1:0]     cfg_total_slots_i,
  input  logic [MAX_SLOTS-1:0] cfg_slot_mask_i,
  input  logic [FB_W-1:0]      cfg_fs_width_i,
  input  logic                 cfg_fs_pol_i,
  input  logic                 cfg_bit_shift_i,
  input  logic                 cfg_lsb_first_i,
  input  logic                 cfg_skip_mask_i,
  input  logic                 s_valid_i,
  input  logic [MAX_BITS-1:0]  s_data_i,
  output logic                 s_ready_o,
  output logic                 bclk_en_o,
  output logic                 ws_o,
  output logic                 sd_o,
  output logic                 underrun_o
);
  logic [DIV_W-1:0]     div;
  logic [BITS_W-1:0]    slot_bits, data_bits;
  logic [CNT_W-1:0]     nslots;
  logic [FB_W-1:0]      frame_bits, fs_width;
  logic                 fs_pol, bit_shift, lsb_first, skip_mask;
  logic [MAX_SLOTS-1:0] slot_mask;
  logic [SLOT_W-1:0]    slot_idx;
  logic [BIT_W-1:0]     bit_idx, sel;
  logic                 tick, slot_start, active, consume, u_bit, u_prev_q;
  logic [MAX_BITS-1:0]  load_val, word_now, cur_word_q;

  tdm_tx_cfg #(.MAX_SLOTS(MAX_SLOTS), .MAX_BITS(MAX_BITS), .DIV_W(DIV_W)) cfg_i (
    .clk_i, .rst_ni, .en_i,
    .div_i(cfg_div_i), .slot_bits_i(cfg_slot_bits_i), .data_bits_i(cfg_data_bits_i),
    .total_slots_i(cfg_total_slots_i), .slot_mask_i(cfg_slot_mask_i),
    .fs_width_i(cfg_fs_width_i), .fs_pol_i(cfg_fs_pol_i), .bit_shift_i(cfg_bit_shift_i),
    .lsb_first_i(cfg_lsb_first_i), .skip_mask_i(cfg_skip_mask_i),
    .div_o(div), .slot_bits_o(slot_bits), .data_bits_o(data_bits), .nslots_o(nslots),
    .frame_bits_o(frame_bits), .fs_width_o(fs_width), .fs_pol_o(fs_pol),
    .bit_shift_o(bit_shift), .lsb_first_o(lsb_first), .skip_mask_o(skip_mask),
    .slot_mask_o(slot_mask)
  );

  tdm_tx_clkdiv #(.DIV_W(DIV_W)) div_i (
    .clk_i, .rst_ni, .run_i(en_i), .div_i(div), .tick_o(tick)
  );

  tdm_tx_seq #(.MAX_SLOTS(MAX_SLOTS), .MAX_BITS(MAX_BITS)) seq_i (
    .clk_i, .rst_ni, .run_i(en_i), .tick_i(tick),
    .slot_bits_i(slot_bits), .nslots_i(nslots), .frame_bits_i(frame_bits),
    .fs_width_i(fs_width), .fs_pol_i(fs_pol),
    .slot_o(slot_idx), .bit_o(bit_idx), .ws_o(ws_o)
  );

  assign bclk_en_o  = tick;
  assign slot_start = (bit_idx == '0);
  assign active     = slot_mask[slot_idx];
  assign consume    = skip_mask ? active : 1'b1;
  assign s_ready_o  = tick && slot_start && consume;

  // words for disabled slots are taken but dropped
  assign load_val = (active && s_valid_i) ? s_data_i : '0;
  assign word_now = slot_start ? load_val : cur_word_q;
  assign sel      = lsb_first ? bit_idx
                              : BIT_W'(data_bits - BITS_W'(1) - BITS_W'(bit_idx));
  assign u_bit    = (BITS_W'(bit_idx) < data_bits) ? word_now[sel] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_word_q <= '0;
      u_prev_q   <= 1'b0;
      sd_o       <= 1'b0;
      underrun_o <= 1'b0;
    end else if (!en_i) begin
      cur_word_q <= '0;
      u_prev_q   <= 1'b0;
      sd_o       <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      underrun_o <= tick && slot_start && active && !s_valid_i;
      if (tick) begin
        if (slot_start) cur_word_q <= load_val;
        u_prev_q <= u_bit;
        sd_o     <= bit_shift ? u_prev_q : u_bit;
      end
    end
  end

  AST_UNDERRUN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> ($past(bclk_en_o) && !$past(s_valid_i))); // R8
  AST_SD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !sd_o); // R9
endmodule

// File: tb/tdm_tx_tb_top.sv
`timescale 1ns/1ps
module tdm_tx_tb_top;
  localparam int MS = 8, MB = 32, DW = 8;
  localparam int BW = $clog2(MB + 1), CW = $clog2(MS + 1), FW = $clog2(MS * MB + 1);

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [DW-1:0] c_div; logic [BW-1:0] c_sb, c_db; logic [CW-1:0] c_tot;
  logic [MS-1:0] c_mask; logic [FW-1:0] c_fs;
  logic c_pol, c_shift, c_lsb, c_skip, s_valid;
  logic [MB-1:0] s_data;
  logic s_ready, bclk_en, ws, sd, underrun;

  always #5 clk = ~clk;

  tdm_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .cfg_div_i(c_div), .cfg_slot_bits_i(c_sb), .cfg_data_bits_i(c_db),
    .cfg_total_slots_i(c_tot), .cfg_slot_mask_i(c_mask), .cfg_fs_width_i(c_fs),
    .cfg_fs_pol_i(c_pol), .cfg_bit_shift_i(c_shift), .cfg_lsb_first_i(c_lsb),
    .cfg_skip_mask_i(c_skip), .s_valid_i(s_valid), .s_data_i(s_data),
    .s_ready_o(s_ready), .bclk_en_o(bclk_en), .ws_o(ws), .sd_o(sd), .underrun_o(underrun)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] words [1024];
  int widx = 0; bit fire = 0;
  int und_cnt = 0;
  bit ws_a [2048]; bit sd_a [2048];

  // model settings
  int m_div, m_sb, m_db, m_tot, m_fs; bit [MS-1:0] m_mask;
  bit m_pol, m_shift, m_lsb, m_skip, m_valid;
  int e_div, e_sb, e_db, e_n, e_fb, e_fsw, e_cpf, base;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, act=%0d exp<=190000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (fire) widx++;
    s_data = words[widx % 1024];
    fire = s_valid && s_ready;
    if (underrun) und_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int popc(input bit [MS-1:0] m);
    int c = 0;
    for (int i = 0; i < MS; i++) c += m[i];
    return c;
  endfunction

  task automatic calc();
    int need = 1, tot;
    e_div = (m_div < 8) ? 8 : m_div;
    e_sb  = (m_sb == 0) ? 1 : (m_sb > MB ? MB : m_sb);
    e_db  = (m_db == 0) ? 1 : (m_db > e_sb ? e_sb : m_db);
    for (int i = 0; i < MS; i++) if (m_mask[i]) need = i + 1;
    tot   = (m_tot > MS) ? MS : m_tot;
    e_n   = (tot < need) ? need : tot;
    e_fb  = e_sb * e_n;
    e_fsw = (m_fs == 0) ? e_fb / 2 : m_fs;
    e_cpf = m_skip ? popc(m_mask) : e_n;
  endtask

  function automatic bit u_exp(input int t);
    int p, f, s, b, cnt;
    logic [31:0] w;
    p = t % e_fb; f = t / e_fb; s = p / e_sb; b = p % e_sb; cnt = 0;
    for (int k = 0; k < s; k++) if (!m_skip || m_mask[k]) cnt++;
    if (!m_valid || !m_mask[s] || b >= e_db) return 1'b0;
    w = words[(base + f * e_cpf + cnt) % 1024];
    return m_lsb ? w[b] : w[e_db - 1 - b];
  endfunction

  function automatic bit sd_exp(input int t);
    if (m_shift) return (t == 0) ? 1'b0 : u_exp(t - 1);
    return u_exp(t);
  endfunction

  function automatic bit ws_exp(input int t);
    return ((t % e_fb) < e_fsw) ? m_pol : !m_pol;
  endfunction

  task automatic run_test(input string tag, input int nfr, input bit scramble);
    int nb, got, last, cnum, div_bad, ws_bad, sd_bad, first_t;
    calc();
    @(negedge clk);
    c_div = DW'(m_div); c_sb = BW'(m_sb); c_db = BW'(m_db); c_tot = CW'(m_tot);
    c_mask = m_mask; c_fs = FW'(m_fs); c_pol = m_pol; c_shift = m_shift;
    c_lsb = m_lsb; c_skip = m_skip; s_valid = m_valid;
    @(negedge clk); @(negedge clk);
    base = widx; und_cnt = 0;
    en = 1'b1;
    nb = nfr * e_fb; got = 0; last = -1; cnum = 0; div_bad = 0;
    while (got < nb) begin
      @(negedge clk); cnum++;
      if (bclk_en) begin
        if (last >= 0 && cnum - last != e_div) div_bad++;
        last = cnum;
        @(negedge clk); cnum++;
        ws_a[got] = ws; sd_a[got] = sd; got++;
        if (scramble && got == nb / 2) begin
          c_div = DW'($urandom); c_sb = BW'($urandom); c_db = BW'($urandom);
          c_tot = CW'($urandom); c_mask = MS'($urandom); c_fs = FW'($urandom);
          c_pol = ~m_pol; c_shift = ~m_shift; c_lsb = ~m_lsb; c_skip = ~m_skip;
        end
      end
    end
    en = 1'b0;
    ws_bad = 0; sd_bad = 0; first_t = -1;
    for (int t = 0; t < nb; t++) begin
      if (ws_a[t] != ws_exp(t)) ws_bad++;
      if (sd_a[t] != sd_exp(t)) begin
        sd_bad++;
        if (first_t < 0) first_t = t;
      end
    end
    chk(div_bad == 0, {tag, " R1"}, "bit period mismatches", div_bad, 0);
    chk(ws_bad == 0, {tag, " R2 R3"}, "frame sync mismatches", ws_bad, 0);
    chk(sd_bad == 0, {tag, " R4 R5 R6"}, "data mismatches (first index in msg)", sd_bad, 0);
    if (sd_bad != 0) $display("  first data mismatch at bit %0d", first_t);
    chk(widx - base == (m_valid ? nfr * e_cpf : 0), {tag, " R7"}, "words consumed",
        widx - base, m_valid ? nfr * e_cpf : 0);
    chk(und_cnt == (m_valid ? 0 : nfr * popc(m_mask)), {tag, " R8"}, "underrun pulses",
        und_cnt, m_valid ? 0 : nfr * popc(m_mask));
    if (!scramble) begin
      int idle_bad = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (bclk_en || s_ready || sd || underrun || ws != !m_pol) idle_bad++;
      end
      chk(idle_bad == 0, {tag, " R9"}, "idle outputs wrong", idle_bad, 0);
    end else begin
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic set_m(input int dv, sb, db, tot, input bit [MS-1:0] mk, input int fs,
                       input bit pol, sh, lsb, sk, vl);
    m_div = dv; m_sb = sb; m_db = db; m_tot = tot; m_mask = mk; m_fs = fs;
    m_pol = pol; m_shift = sh; m_lsb = lsb; m_skip = sk; m_valid = vl;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) words[i] = $urandom;
    c_div = 8; c_sb = 16; c_db = 16; c_tot = 2; c_mask = 3; c_fs = 0;
    c_pol = 0; c_shift = 0; c_lsb = 0; c_skip = 0; s_valid = 0; s_data = words[0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset / idle state R9
    chk(!bclk_en && !s_ready && !sd && !underrun, "R9", "outputs after reset",
        {bclk_en, s_ready, sd, underrun}, 0);
    chk(ws == 1'b1, "R9", "ws idle level after reset", ws, 1);

    // two-slot half-frame sync, delayed data
    set_m(8, 16, 16, 2, 8'b11, 0, 0, 1, 0, 0, 1);     run_test("std R5", 2, 0);
    // one-bit sync pulse, active high
    set_m(9, 8, 8, 4, 8'b1111, 1, 1, 1, 0, 0, 1);     run_test("pulse R3", 2, 0);
    // sample-long sync, no delay
    set_m(8, 16, 16, 4, 8'b1111, 16, 1, 0, 0, 0, 1);  run_test("long R3", 2, 0);
    // narrow data, lsb first, sparse mask, every slot consumes
    set_m(8, 16, 12, 4, 8'b0101, 0, 0, 0, 1, 0, 1);   run_test("narrow R4 R6 R7", 2, 0);
    // same with skip
    set_m(8, 16, 12, 4, 8'b0101, 0, 0, 0, 1, 1, 1);   run_test("skip R7", 2, 0);
    // total below highest enabled slot
    set_m(8, 8, 8, 2, 8'b0010_0001, 0, 0, 0, 0, 1, 1); run_test("len R2", 2, 0);
    // auto slot count, data wider than slot clamps
    set_m(8, 6, 20, 0, 8'b0011, 0, 1, 0, 0, 0, 1);    run_test("auto R2 R4", 2, 0);
    // divider below minimum and above
    set_m(3, 8, 8, 2, 8'b11, 0, 0, 0, 0, 0, 1);       run_test("divlo R1", 1, 0);
    set_m(13, 8, 8, 2, 8'b11, 0, 0, 0, 0, 0, 1);      run_test("divhi R1", 1, 0);
    // starvation
    set_m(8, 8, 8, 4, 8'b0101, 2, 1, 0, 0, 1, 0);     run_test("starve R8", 2, 0);
    set_m(8, 8, 8, 4, 8'b1001, 0, 0, 1, 0, 0, 0);     run_test("starve2 R8", 1, 0);
    // configuration disturbed mid-run
    set_m(8, 12, 10, 3, 8'b101, 3, 1, 1, 0, 1, 1);    run_test("hold R10", 2, 1);

    for (int r = 0; r < 10; r++) begin
      int sb;
      sb = $urandom_range(4, 16);
      set_m($urandom_range(0, 12), sb, $urandom_range(1, sb + 2), $urandom_range(0, 8),
            8'($urandom_range(1, 255)), ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, sb * 2),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1);
      run_test("rand R4 R6 R7", 2, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule